// File: doc/BRIEF.md
# Companion-chip bus window decoder

This block sits between a host bus and a USB controller core on a companion device. The host issues 8-, 16- and 32-bit reads and writes into a 4 KB window, and the block decides where each access goes. Two 512-byte regions go straight through to the attached core's register port. In one of them, the FIFO region, the host address is folded onto the core's per-endpoint FIFO offsets. The rest of the window holds a small local register file. That file has device configuration, an endpoint-0 setup register, two arrays of per-endpoint transfer sizes, a scratch word, a test word, a few general configuration words, and some read-only revision and identifier constants.

Requests arrive on a valid/ready channel. Each accepted request produces exactly one response one cycle later on a valid/ready response channel. A response that is not taken is held, and it blocks new requests until the host drains it. Writes to endpoint size registers are announced to the core on a size port with a one-cycle strobe.

Top module: `usbc_bus_window`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high exactly when no response is pending or the pending one is being taken (`rsp_ready` high). Each accepted request raises `rsp_valid` on the next cycle. While `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold. A write's response data is zero.
- R2: Only `req_addr[11:0]` (the offset) is decoded, and higher address bits are ignored.
- R3: Offsets 0x400–0x5FF reach the core port for any access size. The core offset is `offset[8:0]`, the size and write data pass through, and read data is the core's `core_rdata`.
- R4: Offsets 0x600–0x7FF also reach the core port, at core offset 0x20 + {offset[8:5], 2'b00} (so 0x20..0x5C, word aligned).
- R5: `req_size` encodes 0 = byte, 1 = halfword, 2 = word. Outside the two core regions, a non-word access reads zero and its write is dropped.
- R6: An offset that names no register reads zero, and writes to it change nothing.
- R7: A word write to 0x908 keeps only bits [8:0]. On the next cycle it pulses `epsz_strobe` with endpoint 0, size = bits [6:0] and `epsz_tx` = bit 7.
- R8: Transmit sizes live at 0x90C + 4·i and receive sizes at 0x94C + 4·i, for i = 0..14. Any offset inside an entry's 4-byte slot selects that entry. A word write stores 32 bits. On the next cycle it pulses `epsz_strobe` with endpoint i+1, size = bits [30:0], and `epsz_tx` 1 for transmit or 0 for receive.
- R9: After reset, the 16-bit test word at 0x9D8 reads 0xA596, and every other writable register reads zero. The test word and the scratch word at 0x9C4 are read/write.
- R10: Reads return the constants 0x20 at 0x814 and 0x838, 0x30 at 0x880 and 0x900, 0xA9453C59 at 0x9F8 and 0x54059ADF at 0x9FC. Writes there have no effect.
- R11: The device configuration word at 0x800 is read/write, and `host_mode` follows its bit 16. Writing it with bit 15 set makes `test_mode_err` high until reset.
- R12: General configuration words at 0x818, 0x81C, 0x884, 0x904 and 0x948 are plain 32-bit read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address; low 12 bits decoded |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| core_valid | output | 1 | Core port access this cycle |
| core_write | output | 1 | Core port write |
| core_size | output | 2 | Core port access size |
| core_addr | output | 9 | Core register offset |
| core_wdata | output | DATA_W | Core write data |
| core_rdata | input | DATA_W | Core read data, same cycle |
| epsz_strobe | output | 1 | One-cycle endpoint size update |
| epsz_num | output | EP_NUM_W | Endpoint number (0..NUM_EP) |
| epsz_len | output | EP_SIZE_W | Transfer size |
| epsz_tx | output | 1 | 1 = transmit direction |
| host_mode | output | 1 | Host mode from device configuration |
| test_mode_err | output | 1 | Sticky flag: test mode was requested |

## Verification
The bench builds the block with its defaults: a 16-bit address, 15 endpoints per direction and 31-bit sizes. The 16-bit address leaves four bits above the decoded offset, so folding is observable (R2). Fifteen entries put both the first and the last slot of each size array, and the unaligned offsets inside a slot, within reach of short directed sequences. A behavioural model of the register file and of the core stand-in predicts the response, core port, size port and flags every cycle, including a stretch where the response is held back.

// File: rtl/usbc_win_pkg.sv
package usbc_win_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} acc_size_e;
  typedef enum logic [1:0] {RGN_CORE, RGN_FIFO, RGN_LOCAL, RGN_NONE} region_e;

  localparam int OFF_W   = 12;
  localparam int CORE_AW = 9;

  localparam logic [OFF_W-1:0] OFF_DEVCFG  = 12'h800;
  localparam logic [OFF_W-1:0] OFF_REV_A0  = 12'h814;
  localparam logic [OFF_W-1:0] OFF_REV_A1  = 12'h838;
  localparam logic [OFF_W-1:0] OFF_REV_B0  = 12'h880;
  localparam logic [OFF_W-1:0] OFF_REV_B1  = 12'h900;
  localparam logic [OFF_W-1:0] OFF_EP0     = 12'h908;
  localparam logic [OFF_W-1:0] OFF_TX_BASE = 12'h90C;
  localparam logic [OFF_W-1:0] OFF_RX_BASE = 12'h94C;
  localparam logic [OFF_W-1:0] OFF_SCRATCH = 12'h9C4;
  localparam logic [OFF_W-1:0] OFF_TEST    = 12'h9D8;
  localparam logic [OFF_W-1:0] OFF_ID_LO   = 12'h9F8;
  localparam logic [OFF_W-1:0] OFF_ID_HI   = 12'h9FC;

  localparam logic [31:0] REV_A_VAL = 32'h0000_0020;
  localparam logic [31:0] REV_B_VAL = 32'h0000_0030;
  localparam logic [31:0] ID_LO_VAL = 32'hA945_3C59;
  localparam logic [31:0] ID_HI_VAL = 32'h5405_9ADF;
  localparam logic [15:0] TEST_RST  = 16'hA596;

  localparam int NUM_PLAIN = 5;
  localparam logic [OFF_W-1:0] PLAIN_OFFS [NUM_PLAIN] = '{12'h818, 12'h81C, 12'h884, 12'h904, 12'h948};

  localparam logic [CORE_AW-1:0] FIFO_CORE_BASE = 9'h020;
endpackage

// File: rtl/usbc_win_decode.sv
module usbc_win_decode
  import usbc_win_pkg::*;
(
  input  logic [OFF_W-1:0]   off,
  output region_e            region,
  output logic [CORE_AW-1:0] core_off
);
  always_comb begin
    case (off[11:9])
      3'b010:  region = RGN_CORE;
      3'b011:  region = RGN_FIFO;
      3'b100:  region = RGN_LOCAL;
      default: region = RGN_NONE;
    endcase
  end

  // FIFO region: address bits [8:5] pick the endpoint FIFO word in the core
  always_comb begin
    if (region == RGN_FIFO)
      core_off = FIFO_CORE_BASE + {3'b000, off[8:5], 2'b00};
    else
      core_off = off[CORE_AW-1:0];
  end
endmodule

// File: rtl/usbc_win_regs.sv
module usbc_win_regs
  import usbc_win_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_EP    = 15,
  parameter int EP_SIZE_W = 31,
  localparam int EP_NUM_W = $clog2(NUM_EP + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OFF_W-1:0]     off,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic                 host_mode,
  output logic                 test_mode_err,
  output logic                 epsz_strobe,
  output logic [EP_NUM_W-1:0]  epsz_num,
  output logic [EP_SIZE_W-1:0] epsz_len,
  output logic                 epsz_tx
);
  localparam int SLOT_W = OFF_W - 2;

  logic [DATA_W-1:0] devcfg, scratch;
  logic [8:0]        ep0cfg;
  logic [15:0]       testw;
  logic [DATA_W-1:0] tx_arr    [NUM_EP];
  logic [DATA_W-1:0] rx_arr    [NUM_EP];
  logic [DATA_W-1:0] plain_arr [NUM_PLAIN];
  logic [NUM_EP-1:0]    tx_hit, rx_hit;
  logic [NUM_PLAIN-1:0] plain_hit;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep_hit
    assign tx_hit[e] = (off[OFF_W-1:2] == SLOT_W'(int'(OFF_TX_BASE[OFF_W-1:2]) + e));
    assign rx_hit[e] = (off[OFF_W-1:2] == SLOT_W'(int'(OFF_RX_BASE[OFF_W-1:2]) + e));
  end

  for (genvar p = 0; p < NUM_PLAIN; p++) begin : g_plain_hit
    assign plain_hit[p] = (off == PLAIN_OFFS[p]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      devcfg        <= '0;
      scratch       <= '0;
      ep0cfg        <= '0;
      testw         <= TEST_RST;
      test_mode_err <= 1'b0;
      for (int e = 0; e < NUM_EP; e++) begin
        tx_arr[e] <= '0;
        rx_arr[e] <= '0;
      end
      for (int p = 0; p < NUM_PLAIN; p++) plain_arr[p] <= '0;
    end else if (wr_en) begin
      if (off == OFF_DEVCFG) begin
        devcfg <= wdata;
        if (wdata[15]) test_mode_err <= 1'b1;
      end
      if (off == OFF_SCRATCH) scratch <= wdata;
      if (off == OFF_TEST)    testw   <= wdata[15:0];
      if (off == OFF_EP0)     ep0cfg  <= wdata[8:0];
      for (int e = 0; e < NUM_EP; e++) begin
        if (tx_hit[e]) tx_arr[e] <= wdata;
        if (rx_hit[e]) rx_arr[e] <= wdata;
      end
      for (int p = 0; p < NUM_PLAIN; p++)
        if (plain_hit[p]) plain_arr[p] <= wdata;
    end
  end

  // size announcement to the core, one cycle after the accepted write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epsz_strobe <= 1'b0;
      epsz_num    <= '0;
      epsz_len    <= '0;
      epsz_tx     <= 1'b0;
    end else begin
      epsz_strobe <= 1'b0;
      if (wr_en) begin
        if (off == OFF_EP0) begin
          epsz_strobe <= 1'b1;
          epsz_num    <= '0;
          epsz_len    <= EP_SIZE_W'(wdata[6:0]);
          epsz_tx     <= wdata[7];
        end
        for (int e = 0; e < NUM_EP; e++) begin
          if (tx_hit[e] || rx_hit[e]) begin
            epsz_strobe <= 1'b1;
            epsz_num    <= EP_NUM_W'(e + 1);
            epsz_len    <= wdata[EP_SIZE_W-1:0];
            epsz_tx     <= tx_hit[e];
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (off)
      OFF_DEVCFG:              rdata = devcfg;
      OFF_REV_A0, OFF_REV_A1:  rdata = REV_A_VAL;
      OFF_REV_B0, OFF_REV_B1:  rdata = REV_B_VAL;
      OFF_ID_LO:               rdata = ID_LO_VAL;
      OFF_ID_HI:               rdata = ID_HI_VAL;
      OFF_EP0:                 rdata = DATA_W'(ep0cfg);
      OFF_SCRATCH:             rdata = scratch;
      OFF_TEST:                rdata = DATA_W'(testw);
      default:                 rdata = '0;
    endcase
    for (int e = 0; e < NUM_EP; e++) begin
      if (tx_hit[e]) rdata = tx_arr[e];
      if (rx_hit[e]) rdata = rx_arr[e];
    end
    for (int p = 0; p < NUM_PLAIN; p++)
      if (plain_hit[p]) rdata = plain_arr[p];
  end

  assign host_mode = devcfg[16];
endmodule

// File: rtl/usbc_bus_window.sv
module usbc_bus_window
  import usbc_win_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int NUM_EP    = 15,
  parameter int EP_SIZE_W = 31,
  localparam int EP_NUM_W = $clog2(NUM_EP + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 core_valid,
  output logic                 core_write,
  output logic [1:0]           core_size,
  output logic [CORE_AW-1:0]   core_addr,
  output logic [DATA_W-1:0]    core_wdata,
  input  logic [DATA_W-1:0]    core_rdata,
  output logic                 epsz_strobe,
  output logic [EP_NUM_W-1:0]  epsz_num,
  output logic [EP_SIZE_W-1:0] epsz_len,
  output logic                 epsz_tx,
  output logic                 host_mode,
  output logic                 test_mode_err
);
  logic [OFF_W-1:0]  off;
  region_e           region;
  logic              fire, is_word, in_core, local_wr;
  logic [DATA_W-1:0] loc_rdata, rd_val;

  assign off     = req_addr[OFF_W-1:0];
  assign fire    = req_valid && req_ready;
  assign is_word = (req_size == SZ_WORD);

  usbc_win_decode u_dec (
    .off      (off),
    .region   (region),
    .core_off (core_addr)
  );

  assign in_core    = (region == RGN_CORE) || (region == RGN_FIFO);
  assign core_valid = fire && in_core;
  assign core_write = req_write;
  assign core_size  = req_size;
  assign core_wdata = req_wdata;
  assign local_wr   = fire && req_write && is_word && (region == RGN_LOCAL);

  usbc_win_regs #(
    .DATA_W    (DATA_W),
    .NUM_EP    (NUM_EP),
    .EP_SIZE_W (EP_SIZE_W)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .off           (off),
    .wr_en         (local_wr),
    .wdata         (req_wdata),
    .rdata         (loc_rdata),
    .host_mode     (host_mode),
    .test_mode_err (test_mode_err),
    .epsz_strobe   (epsz_strobe),
    .epsz_num      (epsz_num),
    .epsz_len      (epsz_len),
    .epsz_tx       (epsz_tx)
  );

  always_comb begin
    if (req_write)                                rd_val = '0;
    else if (in_core)                             rd_val = core_rdata;
    else if (is_word && region == RGN_LOCAL)      rd_val = loc_rdata;
    else                                          rd_val = '0;
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/usbc_win_chk.sv
module usbc_win_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              core_valid,
  input logic [8:0]        core_addr,
  input logic              epsz_strobe,
  input logic              test_mode_err
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)) else $error("rsp hold"); // R1
  AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready) else $error("accept while full"); // R1
  AST_RSP_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid) else $error("no response"); // R1
  AST_CORE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid |-> req_valid && req_ready && req_addr[11:10] == 2'b01) else $error("core outside window"); // R3
  AST_FIFO_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid && req_addr[11:9] == 3'b011 |-> core_addr[1:0] == 2'b00 && core_addr >= 9'h020 && core_addr <= 9'h05C)
    else $error("fifo remap range"); // R4
  AST_STB_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> !epsz_strobe) else $error("strobe after read"); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode_err |=> test_mode_err) else $error("error flag dropped"); // R11
endmodule

bind usbc_bus_window usbc_win_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .req_write     (req_write),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_rdata     (rsp_rdata),
  .core_valid    (core_valid),
  .core_addr     (core_addr),
  .epsz_strobe   (epsz_strobe),
  .test_mode_err (test_mode_err)
);

// File: tb/sim_usbc_bus_window.sv
`timescale 1ns/1ps
module sim_usbc_bus_window;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int NUM_EP = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_size = 2'd2;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, core_valid, core_write, epsz_strobe, epsz_tx, host_mode, test_mode_err;
  logic [DATA_W-1:0] rsp_rdata, core_wdata, core_rdata;
  logic [1:0] core_size;
  logic [8:0] core_addr;
  logic [3:0] epsz_num;
  logic [30:0] epsz_len;

  always #5 clk = ~clk;

  usbc_bus_window u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .core_valid(core_valid), .core_write(core_write), .core_size(core_size),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .epsz_strobe(epsz_strobe), .epsz_num(epsz_num), .epsz_len(epsz_len), .epsz_tx(epsz_tx),
    .host_mode(host_mode), .test_mode_err(test_mode_err)
  );

  // core stand-in: plain register array
  logic [31:0] core_mem [512];
  assign core_rdata = core_mem[core_addr];
  always @(posedge clk) if (core_valid && core_write) core_mem[core_addr] <= core_wdata;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_cmem [512];
  logic [31:0] m_tx [NUM_EP], m_rx [NUM_EP], m_plain [int];
  logic [31:0] m_dev, m_scr, m_ep0;
  logic [15:0] m_tst;
  bit m_err, m_rv, m_stb, m_stx;
  logic [31:0] m_rd, m_len;
  int m_num;
  int plain_list [5] = '{'h818, 'h81C, 'h884, 'h904, 'h948};

  function automatic bit in_core(int off); return off >= 'h400 && off < 'h800; endfunction
  function automatic int rc_addr(int off);
    if (off >= 'h600) return 'h20 + ((off >> 3) & 'h3C);
    return off & 'h1FF;
  endfunction

  task automatic m_reset();
    m_dev = 0; m_scr = 0; m_ep0 = 0; m_tst = 16'hA596; m_err = 0;
    m_rv = 0; m_stb = 0;
    for (int e = 0; e < NUM_EP; e++) begin m_tx[e] = 0; m_rx[e] = 0; end
    foreach (plain_list[p]) m_plain[plain_list[p]] = 0;
  endtask

  function automatic logic [31:0] ref_read(int off, int sz);
    if (in_core(off)) return m_cmem[rc_addr(off)];
    if (sz != 2) return 0;
    if (off >= 'h90C && off < 'h948) return m_tx[(off - 'h90C) >> 2];
    if (off >= 'h94C && off < 'h988) return m_rx[(off - 'h94C) >> 2];
    if (m_plain.exists(off)) return m_plain[off];
    case (off)
      'h800: return m_dev;
      'h814, 'h838: return 32'h20;
      'h880, 'h900: return 32'h30;
      'h9F8: return 32'hA9453C59;
      'h9FC: return 32'h54059ADF;
      'h908: return m_ep0;
      'h9C4: return m_scr;
      'h9D8: return {16'h0, m_tst};
      default: return 0;
    endcase
  endfunction

  task automatic ref_write(int off, int sz, logic [31:0] wd);
    if (in_core(off)) begin m_cmem[rc_addr(off)] = wd; return; end
    if (sz != 2) return;
    if (off >= 'h90C && off < 'h948) begin
      m_tx[(off - 'h90C) >> 2] = wd; m_stb = 1; m_num = ((off - 'h90C) >> 2) + 1; m_len = {1'b0, wd[30:0]}; m_stx = 1;
    end else if (off >= 'h94C && off < 'h988) begin
      m_rx[(off - 'h94C) >> 2] = wd; m_stb = 1; m_num = ((off - 'h94C) >> 2) + 1; m_len = {1'b0, wd[30:0]}; m_stx = 0;
    end else if (m_plain.exists(off)) m_plain[off] = wd;
    else case (off)
      'h800: begin m_dev = wd; if (wd[15]) m_err = 1; end
      'h908: begin m_ep0 = {23'h0, wd[8:0]}; m_stb = 1; m_num = 0; m_len = {25'h0, wd[6:0]}; m_stx = wd[7]; end
      'h9C4: m_scr = wd;
      'h9D8: m_tst = wd[15:0];
      default: ;
    endcase
  endtask

  // per-clock model step and comparison
  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int off;
      bit fire;
      off  = int'(req_addr[11:0]);
      fire = req_valid && (!m_rv || rsp_ready);
      m_stb = 0;
      if (fire) begin
        if (req_write) begin m_rd = 0; ref_write(off, int'(req_size), req_wdata); end
        else m_rd = ref_read(off, int'(req_size));
        m_rv = 1;
      end else if (rsp_ready) m_rv = 0;
      #2;
      chk("R1 rsp_valid", {31'h0, rsp_valid}, {31'h0, m_rv});
      if (m_rv) chk("R1/R3/R5/R6 rsp_rdata", rsp_rdata, m_rd);
      chk("R7/R8 epsz_strobe", {31'h0, epsz_strobe}, {31'h0, m_stb});
      if (m_stb) begin
        chk("R7/R8 epsz_num", {28'h0, epsz_num}, m_num);
        chk("R7/R8 epsz_len", {1'b0, epsz_len}, m_len);
        chk("R7/R8 epsz_tx", {31'h0, epsz_tx}, {31'h0, m_stx});
      end
      chk("R11 host_mode", {31'h0, host_mode}, {31'h0, m_dev[16]});
      chk("R11 test_mode_err", {31'h0, test_mode_err}, {31'h0, m_err});
    end
  end

  // core port check in the middle of each request cycle
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      int off;
      bit fire;
      off  = int'(req_addr[11:0]);
      fire = req_valid && (!m_rv || rsp_ready);
      chk("R1 req_ready", {31'h0, req_ready}, {31'h0, (!m_rv || rsp_ready)});
      chk("R3/R4 core_valid", {31'h0, core_valid}, {31'h0, fire && in_core(off)});
      if (fire && in_core(off)) begin
        chk("R3/R4 core_addr", {23'h0, core_addr}, rc_addr(off));
        chk("R3 core_size", {30'h0, core_size}, {30'h0, req_size});
        chk("R3 core_write", {31'h0, core_write}, {31'h0, req_write});
        if (req_write) chk("R3 core_wdata", core_wdata, req_wdata);
      end
    end
  end

  task automatic acc(bit wr, int sz, logic [ADDR_W-1:0] a, logic [31:0] wd);
    bit ok;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = 2'(sz); req_addr = a; req_wdata = wd;
    do begin #1; ok = req_ready; @(posedge clk); end while (!ok);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin core_mem[i] = 32'hC0DE0000 | i; m_cmem[i] = 32'hC0DE0000 | i; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    // R9 reset state
    chk("R9 reset rsp_valid", {31'h0, rsp_valid}, 0);
    chk("R9 reset host_mode", {31'h0, host_mode}, 0);
    acc(0, 2, 16'h09D8, 0);           // R9 test word reset
    acc(0, 2, 16'h09C4, 0);           // R9 scratch reset
    acc(1, 2, 16'h09C4, 32'hDEADBEEF); acc(0, 2, 16'h09C4, 0);   // R9
    acc(1, 2, 16'h09D8, 32'h12341234); acc(0, 2, 16'h09D8, 0);   // R9
    // R10 constants and write immunity
    acc(1, 2, 16'h0814, 32'hFFFFFFFF);
    foreach (u_consts[k]) acc(0, 2, u_consts[k], 0);
    // R11 device config
    acc(1, 2, 16'h0800, 32'h0001_0000); acc(0, 2, 16'h0800, 0);
    acc(1, 2, 16'h0800, 32'h0000_8000); acc(0, 2, 16'h0800, 0);
    // R7 endpoint 0
    acc(1, 2, 16'h0908, 32'hFFFFFFFF); acc(0, 2, 16'h0908, 0);
    acc(1, 2, 16'h0908, 32'h0000_0045);
    // R8 size arrays: first, last, unaligned
    acc(1, 2, 16'h090C, 32'hFFFF_FFFF); acc(1, 2, 16'h0944, 32'h0000_1234);
    acc(1, 2, 16'h094F, 32'h0000_0200); acc(1, 2, 16'h0960, 32'h8000_0040);
    acc(0, 2, 16'h090C, 0); acc(0, 2, 16'h0946, 0); acc(0, 2, 16'h094C, 0); acc(0, 2, 16'h0960, 0);
    // R12 general config words
    foreach (plain_list[p]) begin
      acc(1, 2, ADDR_W'(plain_list[p]), 32'hA5000000 | p);
      acc(0, 2, ADDR_W'(plain_list[p]), 0);
    end
    // R3 core window, all sizes
    acc(1, 0, 16'h0410, 32'h0000_00AB); acc(0, 0, 16'h0410, 0);
    acc(1, 1, 16'h05FE, 32'h0000_BEEF); acc(0, 2, 16'h05FE, 0);
    // R4 FIFO remap
    acc(1, 2, 16'h06E0, 32'h1111_2222); acc(0, 1, 16'h06E4, 0);
    acc(0, 2, 16'h0600, 0); acc(0, 0, 16'h07FF, 0);
    // R5 sub-word outside core regions
    acc(1, 1, 16'h09C4, 32'h0000_5555); acc(0, 2, 16'h09C4, 0); acc(0, 1, 16'h09C4, 0);
    acc(1, 0, 16'h0908, 32'h0000_0011); acc(0, 2, 16'h0908, 0);
    // R6 unknown offsets
    acc(1, 2, 16'h0A00, 32'h7777_7777); acc(0, 2, 16'h0A00, 0);
    acc(1, 2, 16'h0004, 32'h7777_7777); acc(0, 2, 16'h0004, 0); acc(0, 2, 16'h09C8, 0);
    // R2 upper address bits ignored
    acc(1, 2, 16'hF9C4, 32'h0BAD_CAFE); acc(0, 2, 16'h39C4, 0); acc(0, 2, 16'h7410, 0);
    // R1 back-pressure: response held, second request stalls
    @(negedge clk); rsp_ready = 0;
    acc(0, 2, 16'h09C4, 0);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_size = 2'd2; req_addr = 16'h09D8;
    repeat (3) @(negedge clk);
    rsp_ready = 1;
    @(negedge clk); req_valid = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  logic [ADDR_W-1:0] u_consts [6] = '{16'h0814, 16'h0838, 16'h0880, 16'h0900, 16'h09F8, 16'h09FC};

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule